// File: doc/BRIEF.md
# Fractional-N Division Ratio Sequencer

This block supplies the feedback divider of a fractional-N synthesizer with one integer division value for each phase-detector reference cycle. A programmed integer part, fractional numerator, modulus and prescaler choice set up the block. A three-stage cascaded noise-shaping modulator adds a small signed correction to the integer part on every advance strobe. Over any long stretch, the mean of the values sent out equals the integer part plus the numerator divided by the modulus. The modulus can be any value from 2 to 4095, so it does not have to be a power of two.

Software writes a whole configuration through one load strobe. The block checks it at once against the legal ranges. A legal configuration waits until the next advance strobe, which applies it, clears the modulator and sends out the bare integer part. An illegal configuration raises an error flag and is never applied. When integer-only operation is requested and the numerator is zero, the modulator is bypassed and the integer part repeats unchanged.

Top module: `frac_div_seq`

## Requirements
- R1: After reset `div_out` is 0 and `cfg_err` is 0.
- R2: A configuration written with `cfg_wr` leaves `div_out` unchanged until the next `step`. That step sends out exactly the new integer part and clears all modulator state.
- R3: On each `cfg_wr`, `cfg_err` is updated to the verdict on the written values and holds that verdict until the next write. It is 1 when the modulus is below 2, or the numerator is not below the modulus, or the integer part is below its minimum. The minimum is 23 with `cfg_presc_hi`=0 (4/5 prescaler) and 75 with `cfg_presc_hi`=1 (8/9 prescaler).
- R4: A configuration that raised `cfg_err` is never applied. Later steps continue the sequence of the previously active configuration.
- R5: `div_out` changes only in the cycle after a `step` strobe.
- R6: The modulator is defined as follows. Stage k adds its input to its residue. It raises carry ck when the sum reaches the modulus, and then subtracts the modulus. Stage 1 takes the numerator as its input, and stages 2 and 3 take the new residue of the stage before. The offset is c1 + c2[n] − c2[n−1] + c3[n] − 2·c3[n−1] + c3[n−2]. For integer 100, numerator 1 and modulus 4, the four steps after the applying step give 100, 101, 99, 102.
- R7: While a configuration is running, every output lies between the integer part minus 3 and the integer part plus 4.
- R8: Take the N = k·modulus outputs that follow an applying step. Their sum differs from N·INT + k·FRAC by no less than −1 and no more than +2, for any k.
- R9: With `cfg_int_only`=1 and a numerator of 0, every step sends out the integer part unchanged. With `cfg_int_only`=1 and a non-zero numerator, the modulator still runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Load strobe for the configuration fields |
| cfg_int | input | 16 | Integer part of the division ratio |
| cfg_frac | input | 12 | Fractional numerator |
| cfg_mod | input | 12 | Fractional modulus |
| cfg_presc_hi | input | 1 | 0 selects the 4/5 prescaler, 1 selects 8/9 |
| cfg_int_only | input | 1 | Requests modulator bypass when the numerator is 0 |
| step | input | 1 | Advance strobe, one per reference cycle |
| div_out | output | 17 | Registered division value |
| cfg_err | output | 1 | Verdict on the last written configuration |

## Verification
Several properties are checked on every cycle. Each accumulator residue stays below the active modulus, and the correction stays within −3..+4 of the integer part. The output holds between strobes, an applying step sends out exactly the new integer part, and the bypass repeats it. The active configuration cannot move while the error flag is set. Only the directed scenarios can show the exact sequence of a known configuration, the window sums over multiples of the modulus, and the range checks at each prescaler boundary.

// File: rtl/frac_seq_pkg.sv
package frac_seq_pkg;
    localparam int INT_W = 16;
    localparam int MOD_W = 12;
    localparam int OFS_W = 4;

    typedef struct packed {
        logic [INT_W-1:0] int_val;
        logic [MOD_W-1:0] frac;
        logic [MOD_W-1:0] modulus;
        logic             int_only;
    } div_cfg_t;
endpackage

// File: rtl/frac_seq_acc.sv
module frac_seq_acc #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    input  logic [W-1:0] inc,
    input  logic [W-1:0] modulus,
    output logic [W-1:0] res_nxt,
    output logic         carry
);
    typedef struct packed {
        logic [W-1:0] acc;
    } acc_st_t;

    acc_st_t st_d, st_q;
    logic [W:0] sum_w, dif_w;

    always_comb begin
        sum_w   = {1'b0, st_q.acc} + {1'b0, inc};
        dif_w   = sum_w - {1'b0, modulus};
        carry   = (sum_w >= {1'b0, modulus});
        res_nxt = carry ? dif_w[W-1:0] : sum_w[W-1:0];
        st_d    = st_q;
        if (clr)
            st_d.acc = '0;
        else if (adv)
            st_d.acc = res_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6
    residue_below_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.acc < modulus);
endmodule

// File: rtl/frac_seq_mash.sv
module frac_seq_mash
    import frac_seq_pkg::*;
#(
    parameter int W = MOD_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    adv,
    input  logic [W-1:0]            frac,
    input  logic [W-1:0]            modulus,
    output logic signed [OFS_W-1:0] offset
);
    localparam int STAGES = 3;

    typedef struct packed {
        logic c2_p;
        logic c3_p;
        logic c3_pp;
    } hist_t;

    hist_t          h_d, h_q;
    logic [W-1:0]   stg_in  [STAGES];
    logic [W-1:0]   stg_res [STAGES];
    logic [STAGES-1:0] cy;

    assign stg_in[0] = frac;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g > 0) begin : g_chain
            assign stg_in[g] = stg_res[g-1];
        end
        frac_seq_acc #(.W(W)) u_acc (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr),
            .adv     (adv),
            .inc     (stg_in[g]),
            .modulus (modulus),
            .res_nxt (stg_res[g]),
            .carry   (cy[g])
        );
    end

    always_comb begin
        offset = $signed({3'b000, cy[0]})
               + $signed({3'b000, cy[1]}) - $signed({3'b000, h_q.c2_p})
               + $signed({3'b000, cy[2]}) - $signed({2'b00, h_q.c3_p, 1'b0})
               + $signed({3'b000, h_q.c3_pp});
        h_d = h_q;
        if (clr) begin
            h_d = '0;
        end else if (adv) begin
            h_d.c2_p  = cy[1];
            h_d.c3_p  = cy[2];
            h_d.c3_pp = h_q.c3_p;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    // R7
    offset_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (offset >= -4'sd3) && (offset <= 4'sd4));
endmodule

// File: rtl/frac_seq_cfg.sv
module frac_seq_cfg
    import frac_seq_pkg::*;
#(
    parameter int MIN_INT_LO = 23,
    parameter int MIN_INT_HI = 75
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr,
    input  div_cfg_t wr_cfg,
    input  logic     wr_presc_hi,
    input  logic     adv,
    output div_cfg_t act_cfg,
    output div_cfg_t nxt_cfg,
    output logic     load,
    output logic     err
);
    localparam logic [INT_W-1:0] LIM_LO = INT_W'(MIN_INT_LO);
    localparam logic [INT_W-1:0] LIM_HI = INT_W'(MIN_INT_HI);

    typedef struct packed {
        div_cfg_t pend;
        logic     pend_vld;
        logic     err;
        div_cfg_t act;
    } cfg_st_t;

    cfg_st_t st_d, st_q;
    logic    bad;

    always_comb begin
        bad  = (wr_cfg.int_val < (wr_presc_hi ? LIM_HI : LIM_LO))
             || (wr_cfg.modulus < MOD_W'(2))
             || (wr_cfg.frac >= wr_cfg.modulus);
        load = adv && st_q.pend_vld && !st_q.err;
        st_d = st_q;
        if (load) begin
            st_d.act      = st_q.pend;
            st_d.pend_vld = 1'b0;
        end
        if (wr) begin
            st_d.pend     = wr_cfg;
            st_d.pend_vld = 1'b1;
            st_d.err      = bad;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q              <= '0;
            st_q.act.int_val  <= LIM_LO;
            st_q.act.modulus  <= MOD_W'(2);
            st_q.act.int_only <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_cfg = st_q.act;
    assign nxt_cfg = st_d.act;
    assign err     = st_q.err;

    // R4
    hold_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |=> $stable(st_q.act));
endmodule

// File: rtl/frac_div_seq.sv
module frac_div_seq
    import frac_seq_pkg::*;
#(
    parameter int MIN_INT_LO = 23,
    parameter int MIN_INT_HI = 75
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [INT_W-1:0] cfg_int,
    input  logic [MOD_W-1:0] cfg_frac,
    input  logic [MOD_W-1:0] cfg_mod,
    input  logic             cfg_presc_hi,
    input  logic             cfg_int_only,
    input  logic             step,
    output logic [INT_W:0]   div_out,
    output logic             cfg_err
);
    localparam int OUT_W = INT_W + 1;

    typedef struct packed {
        logic [OUT_W-1:0] div;
    } top_st_t;

    top_st_t                 st_d, st_q;
    div_cfg_t                wr_cfg, act_cfg, nxt_cfg;
    logic                    load, bypass, mash_adv;
    logic signed [OFS_W-1:0] offset, ofs_use;

    assign wr_cfg = '{int_val: cfg_int, frac: cfg_frac, modulus: cfg_mod,
                      int_only: cfg_int_only};

    frac_seq_cfg #(
        .MIN_INT_LO (MIN_INT_LO),
        .MIN_INT_HI (MIN_INT_HI)
    ) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (cfg_wr),
        .wr_cfg      (wr_cfg),
        .wr_presc_hi (cfg_presc_hi),
        .adv         (step),
        .act_cfg     (act_cfg),
        .nxt_cfg     (nxt_cfg),
        .load        (load),
        .err         (cfg_err)
    );

    assign bypass   = act_cfg.int_only && (act_cfg.frac == '0);
    assign mash_adv = step && !load && !bypass;

    frac_seq_mash #(.W(MOD_W)) u_mash (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (load),
        .adv     (mash_adv),
        .frac    (act_cfg.frac),
        .modulus (act_cfg.modulus),
        .offset  (offset)
    );

    always_comb begin
        ofs_use = (load || bypass) ? '0 : offset;
        st_d    = st_q;
        if (step)
            st_d.div = {1'b0, nxt_cfg.int_val}
                     + {{(OUT_W-OFS_W){ofs_use[OFS_W-1]}}, ofs_use};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign div_out = st_q.div;

    // R5
    hold_between_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(div_out));

    // R2
    apply_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (div_out == {1'b0, act_cfg.int_val}));

    // R9
    bypass_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && bypass) |=> (div_out == {1'b0, act_cfg.int_val}));

    // R7
    near_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=>
            (({1'b0, div_out} + (OUT_W+1)'(3)) >= {2'b00, act_cfg.int_val}) &&
            ({1'b0, div_out} <= ({2'b00, act_cfg.int_val} + (OUT_W+1)'(4))));
endmodule

// File: tb/frac_div_seq_bench.sv
module frac_div_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_int = '0;
    logic [11:0] cfg_frac = '0;
    logic [11:0] cfg_mod = '0;
    logic        cfg_presc_hi = 1'b0;
    logic        cfg_int_only = 1'b0;
    logic        step = 1'b0;
    logic [16:0] div_out;
    logic        cfg_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    frac_div_seq u_frac_div_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr       (cfg_wr),
        .cfg_int      (cfg_int),
        .cfg_frac     (cfg_frac),
        .cfg_mod      (cfg_mod),
        .cfg_presc_hi (cfg_presc_hi),
        .cfg_int_only (cfg_int_only),
        .step         (step),
        .div_out      (div_out),
        .cfg_err      (cfg_err)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input int iv, input int fr, input int md,
                             input bit ph, input bit io);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_int = 16'(iv); cfg_frac = 12'(fr);
        cfg_mod = 12'(md); cfg_presc_hi = ph; cfg_int_only = io;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic do_step();
        @(negedge clk); step = 1'b1;
        @(negedge clk); step = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 div_out after reset", div_out, 0);
        check("R1 cfg_err after reset", cfg_err, 0);
    endtask

    task automatic t_known_seq();
        int exp_seq [4] = '{100, 101, 99, 102};
        write_cfg(100, 1, 4, 1'b0, 1'b0);
        check("R3 legal config err", cfg_err, 0);
        repeat (3) @(negedge clk);
        check("R2 output held before step", div_out, 0);
        do_step();
        check("R2 applying step gives INT", div_out, 100);
        for (int i = 0; i < 4; i++) begin
            do_step();
            check("R6 known sequence", div_out, exp_seq[i]);
        end
        repeat (4) @(negedge clk);
        check("R5 output held without step", div_out, 102);
    endtask

    task automatic t_window(input int iv, input int fr, input int md,
                            input bit ph, input int k);
        longint sum = 0;
        longint dev;
        int     oor = 0;
        write_cfg(iv, fr, md, ph, 1'b0);
        check("R3 legal window config", cfg_err, 0);
        do_step();
        check("R2 window apply gives INT", div_out, iv);
        for (int i = 0; i < k * md; i++) begin
            do_step();
            sum += div_out;
            if (int'(div_out) < iv - 3 || int'(div_out) > iv + 4) oor++;
        end
        check("R7 outputs within INT-3..INT+4", oor, 0);
        dev = sum - (longint'(k) * md * iv + longint'(k) * fr);
        check("R8 window sum deviation in -1..2", (dev >= -1 && dev <= 2), 1);
    endtask

    task automatic t_intmode();
        int diff = 0;
        write_cfg(300, 0, 16, 1'b0, 1'b1);
        do_step();
        for (int i = 0; i < 20; i++) begin
            do_step();
            if (div_out != 17'd300) diff++;
        end
        check("R9 bypass repeats INT", diff, 0);
        write_cfg(300, 5, 8, 1'b0, 1'b1);
        do_step();
        diff = 0;
        for (int i = 0; i < 8; i++) begin
            do_step();
            if (div_out != 17'd300) diff++;
        end
        check("R9 nonzero FRAC still modulates", (diff > 0), 1);
    endtask

    task automatic t_errors();
        write_cfg(300, 0, 16, 1'b0, 1'b1);
        do_step();
        check("R2 bypass config applied", div_out, 300);
        write_cfg(22, 0, 16, 1'b0, 1'b1);
        check("R3 INT 22 with 4/5 rejected", cfg_err, 1);
        do_step();
        check("R4 rejected config not applied", div_out, 300);
        write_cfg(74, 0, 16, 1'b1, 1'b1);
        check("R3 INT 74 with 8/9 rejected", cfg_err, 1);
        write_cfg(100, 0, 1, 1'b0, 1'b1);
        check("R3 modulus 1 rejected", cfg_err, 1);
        write_cfg(100, 5, 5, 1'b0, 1'b1);
        check("R3 FRAC equal MOD rejected", cfg_err, 1);
        do_step();
        check("R4 still old config", div_out, 300);
        write_cfg(75, 0, 16, 1'b1, 1'b1);
        check("R3 INT 75 with 8/9 accepted", cfg_err, 0);
        write_cfg(23, 0, 2, 1'b0, 1'b1);
        check("R3 INT 23 with 4/5 accepted", cfg_err, 0);
        do_step();
        check("R2 accepted config applied", div_out, 23);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_known_seq();
        t_window(200, 3, 7, 1'b0, 10);
        t_window(75, 37, 100, 1'b1, 3);
        t_window(1000, 1000, 4095, 1'b0, 1);
        t_window(65535, 4094, 4095, 1'b1, 1);
        t_window(500, 1, 2, 1'b0, 50);
        t_intmode();
        t_errors();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule